// File: doc/BRIEF.md
# Memory-Reference Effective Address Generator

This unit forms the effective address of a memory-reference instruction for a small 8-bit processor. It holds four 16-bit pointer registers, where pointer 0 serves as the program counter, and one 8-bit extension register. For each request it takes three inputs: a decoded mode bit, a 2-bit pointer select and a signed 8-bit displacement. It adds the sign-extended offset to the selected pointer, and in auto-indexing mode it writes the moved value back into that pointer.

The displacement code 0x80 is reserved. When it appears, the extension register, read as a signed byte, takes the place of the offset in both the address sum and the pointer update. All address arithmetic covers only the low 12 bits of a pointer. The top 4 bits pass through unchanged, so addresses wrap inside a 4K page.

A load port presets any pointer or the extension register. A combinational read port shows the current value of any pointer.

Top module: `mref_addr_unit`

## Requirements
- R1: After reset, `ea_valid` is 0, `ea` is 0, and every pointer reads 0 on `rd_ptr`.
- R2: `ea_valid` is 1 in the cycle after a cycle with `start` high, and 0 in the cycle after a cycle with `start` low. `ea` holds its value between requests.
- R3: With `mode`=0 and `psel`=0, `ea` = pointer 0 + sign-extended `disp`, and pointer 0 is unchanged.
- R4: With `mode`=0 and `psel` = 1, 2 or 3, `ea` = selected pointer + sign-extended `disp`, and that pointer is unchanged.
- R5: When `disp` = 0x80, the extension register, read as a signed byte, replaces `disp` as the offset in every mode, including the auto-index write-back.
- R6: With `mode`=1, `psel` ≠ 0 and a negative offset (offset bit 7 = 1), the selected pointer moves by the offset first. `ea` and the new pointer value both equal the moved value.
- R7: With `mode`=1, `psel` ≠ 0 and an offset of zero or more, `ea` equals the old pointer value, and the pointer then takes old value + offset.
- R8: Address arithmetic wraps within bits 11..0. Bits 15..12 of `ea` and of any written-back pointer equal bits 15..12 of the selected pointer.
- R9: With `mode`=1 and `psel`=0, the unit behaves exactly as R3 and pointer 0 is not modified.
- R10: `ld_ptr_en` writes `ld_ptr_val` into pointer `ld_ptr_sel`, and `ld_ext_en` writes `ld_ext_val` into the extension register, both at the next clock edge. `rd_ptr` shows pointer `rd_sel` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request an address computation |
| mode | input | 1 | 1 = auto-index (pointers 1..3 only) |
| psel | input | 2 | Pointer select, 0 = program counter |
| disp | input | 8 | Signed displacement, 0x80 = use extension register |
| ld_ptr_en | input | 1 | Pointer load strobe |
| ld_ptr_sel | input | 2 | Pointer to load |
| ld_ptr_val | input | 16 | Pointer load value |
| ld_ext_en | input | 1 | Extension register load strobe |
| ld_ext_val | input | 8 | Extension register load value |
| rd_sel | input | 2 | Pointer to show on rd_ptr |
| rd_ptr | output | 16 | Selected pointer value |
| ea | output | 16 | Effective address |
| ea_valid | output | 1 | One-cycle strobe, EA ready |

## Verification
Both the effective address and any auto-index write-back land at the clock edge that samples `start`, so each is due exactly one cycle after the request. Loads take effect at the edge that samples the strobe. The bench drives inputs on the falling edge. It reads `ea` and `ea_valid` on the next falling edge, which is half a cycle after the edge that updated them. It reads pointers through `rd_ptr` at that same point. One cycle later it confirms that the strobe has dropped and that `ea` is still held.

// File: rtl/mref_addr_unit.sv
module mref_addr_unit #(
  parameter int PW  = 16,
  parameter int OW  = 8,
  parameter int LOW = 12,
  parameter int NP  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  mode,
  input  logic [$clog2(NP)-1:0] psel,
  input  logic [OW-1:0]         disp,
  input  logic                  ld_ptr_en,
  input  logic [$clog2(NP)-1:0] ld_ptr_sel,
  input  logic [PW-1:0]         ld_ptr_val,
  input  logic                  ld_ext_en,
  input  logic [OW-1:0]         ld_ext_val,
  input  logic [$clog2(NP)-1:0] rd_sel,
  output logic [PW-1:0]         rd_ptr,
  output logic [PW-1:0]         ea,
  output logic                  ea_valid
);
  localparam int SW = $clog2(NP);
  localparam logic [OW-1:0] ESC = {1'b1, {(OW-1){1'b0}}};

  logic [PW-1:0] ptr [NP];
  logic [OW-1:0] ext;

  wire [OW-1:0]  off     = (disp == ESC) ? ext : disp;
  wire [LOW-1:0] off_x   = {{(LOW-OW){off[OW-1]}}, off};
  wire [PW-1:0]  base    = ptr[psel];
  wire [LOW-1:0] low_sum = base[LOW-1:0] + off_x;
  wire [PW-1:0]  moved   = {base[PW-1:LOW], low_sum};
  wire           auto_ix = mode && (psel != '0);
  wire [PW-1:0]  ea_next = (auto_ix && !off[OW-1]) ? base : moved;

  assign rd_ptr = ptr[rd_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) ptr[i] <= '0;
    end else begin
      for (int i = 0; i < NP; i++) begin
        if (ld_ptr_en && ld_ptr_sel == SW'(i))
          ptr[i] <= ld_ptr_val;
        else if (start && auto_ix && psel == SW'(i))
          ptr[i] <= moved;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ext <= '0;
    else if (ld_ext_en) ext <= ld_ext_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea       <= '0;
      ea_valid <= 1'b0;
    end else begin
      ea_valid <= start;
      if (start) ea <= ea_next;
    end
  end

  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ea_valid); // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !ea_valid); // R2
  AST_EA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(ea)); // R2
  AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    ea_valid |-> ea[PW-1:LOW] == $past(base[PW-1:LOW])); // R8
  AST_PC_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    start && psel == '0 && !ld_ptr_en |=> $stable(ptr[0])); // R9
  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ext_en |=> $stable(ext)); // R10

  for (genvar g = 0; g < NP; g++) begin : g_chk
    AST_INDEXED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      start && !mode && !ld_ptr_en |=> $stable(ptr[g])); // R4
  end
endmodule

// File: tb/test_mref_addr_unit.sv
module test_mref_addr_unit;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic        start = 0, mode = 0;
  logic [1:0]  psel = 0, ld_ptr_sel = 0, rd_sel = 0;
  logic [7:0]  disp = 0, ld_ext_val = 0;
  logic        ld_ptr_en = 0, ld_ext_en = 0;
  logic [15:0] ld_ptr_val = 0, rd_ptr, ea;
  logic        ea_valid;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #(CLK_P/2) clk = ~clk;

  mref_addr_unit i_mref_addr_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .psel(psel), .disp(disp),
    .ld_ptr_en(ld_ptr_en), .ld_ptr_sel(ld_ptr_sel), .ld_ptr_val(ld_ptr_val),
    .ld_ext_en(ld_ext_en), .ld_ext_val(ld_ext_val), .rd_sel(rd_sel),
    .rd_ptr(rd_ptr), .ea(ea), .ea_valid(ea_valid));

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic peek(logic [1:0] i, logic [15:0] exp, string tag);
    rd_sel = i;
    #1;
    chk(tag, rd_ptr, exp);
  endtask

  task automatic load_ptr(logic [1:0] i, logic [15:0] v);
    @(negedge clk);
    ld_ptr_en = 1; ld_ptr_sel = i; ld_ptr_val = v;
    @(negedge clk);
    ld_ptr_en = 0;
  endtask

  task automatic load_ext(logic [7:0] v);
    @(negedge clk);
    ld_ext_en = 1; ld_ext_val = v;
    @(negedge clk);
    ld_ext_en = 0;
  endtask

  task automatic run(logic m, logic [1:0] p, logic [7:0] d, logic [15:0] exp_ea,
                     logic [15:0] exp_ptr, string tag);
    @(negedge clk);
    start = 1; mode = m; psel = p; disp = d;
    @(negedge clk);
    start = 0;
    chk({tag, " valid"}, {15'd0, ea_valid}, 16'd1);
    chk({tag, " ea"}, ea, exp_ea);
    peek(p, exp_ptr, {tag, " ptr"});
    @(negedge clk);
    chk({tag, " R2 strobe drop"}, {15'd0, ea_valid}, 16'd0);
    chk({tag, " R2 ea held"}, ea, exp_ea);
  endtask

  task automatic t_reset;
    chk("R1 valid", {15'd0, ea_valid}, 16'd0);
    chk("R1 ea", ea, 16'h0000);
    for (int i = 0; i < 4; i++) peek(2'(i), 16'h0000, "R1 ptr");
  endtask

  task automatic t_load;
    load_ptr(0, 16'h1234);
    load_ptr(1, 16'h5FF0);
    load_ptr(2, 16'h3000);
    load_ptr(3, 16'h2100);
    peek(0, 16'h1234, "R10 p0");
    peek(1, 16'h5FF0, "R10 p1");
    peek(3, 16'h2100, "R10 p3");
  endtask

  task automatic t_pcrel;
    run(0, 0, 8'h10, 16'h1244, 16'h1234, "R3 fwd");
    run(0, 0, 8'hF0, 16'h1224, 16'h1234, "R3 back");
    run(1, 0, 8'h08, 16'h123C, 16'h1234, "R9 pc auto");
  endtask

  task automatic t_indexed;
    run(0, 1, 8'h20, 16'h5010, 16'h5FF0, "R4 R8 wrap up");
    run(0, 3, 8'h7F, 16'h217F, 16'h2100, "R4 max");
  endtask

  task automatic t_ext;
    load_ext(8'h05);
    run(0, 2, 8'h80, 16'h3005, 16'h3000, "R5 ext pos");
    load_ext(8'hFE);
    run(0, 2, 8'h80, 16'h3FFE, 16'h3000, "R5 R8 ext wrap down");
  endtask

  task automatic t_auto;
    run(1, 3, 8'hFC, 16'h20FC, 16'h20FC, "R6 predec");
    run(1, 3, 8'h03, 16'h20FC, 16'h20FF, "R7 postinc");
    run(1, 1, 8'h00, 16'h5FF0, 16'h5FF0, "R7 zero");
    run(1, 1, 8'h20, 16'h5FF0, 16'h5010, "R7 R8 wrap");
    load_ptr(2, 16'h4010);
    load_ext(8'hF8);
    run(1, 2, 8'h80, 16'h4008, 16'h4008, "R5 R6 ext predec");
    load_ext(8'h07);
    run(1, 2, 8'h80, 16'h4008, 16'h400F, "R5 R7 ext postinc");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_load();
    t_pcrel();
    t_indexed();
    t_ext();
    t_auto();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule